// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must jump to an interrupt handler. There are five request sources: two external event inputs, a timer overflow, a time-base tick and a real-time-clock tick. Each source is caught on the rising edge of its event input and held in a request flag.

Two byte-wide control registers on a simple register bus hold the flags, one enable per source and a global master enable. On each service slot, which the core marks with `t2_edge`, the block checks three things: the master enable, the source's own enable and the stack-full input. The pending source with the highest priority wins. The block then pulses `int_take` for one cycle with that source's vector. The same edge clears the winning flag and the master enable.

The core reports its two return instructions on two inputs. The interrupt-return input sets the master enable again. The plain return input leaves the master enable unchanged. A handler that sets the master enable and a source enable itself can be interrupted again.

Top module: `vec_intc`

## Requirements
- R1: Register 0 sits at address 0x0B. Its bits are: bit0 master enable; bits 1, 2 and 3 the enables for external 0, external 1 and timer; bits 4, 5 and 6 the flags for external 0, external 1 and timer. A write loads all seven bits. Bit 7 reads as 0.
- R2: Register 1 sits at address 0x1E. Bit0 is the time-base enable and bit1 the RTC enable. Bit4 is the time-base flag and bit5 the RTC flag. Bits 2, 3, 6 and 7 read as 0. A read of any other address returns 0.
- R3: A 0-to-1 change on a source's event input sets its flag. The flag is visible after the next clock edge. An input that stays high does not set the flag again once the flag has been cleared.
- R4: A set flag stays set while its source is disabled. It clears only when the request is serviced or software writes 0 to it.
- R5: A source is serviced only in a cycle where all of these hold: `t2_edge` is 1, the master enable is 1, the source's enable is 1, its flag is 1 and `stack_full` is 0. `int_take` is then high for exactly the cycle after that edge.
- R6: Priority from highest to lowest is external 0, external 1, timer, time base, RTC. Their vectors are 0x04, 0x08, 0x0C, 0x10 and 0x14. `vector` is 0 whenever `int_take` is 0.
- R7: Accepting a request clears the winning flag and the master enable. All other flags keep their values.
- R8: A pulse on `ret_reti` sets the master enable. A pulse on `ret_plain` leaves it unchanged. An acceptance in the same cycle takes precedence over either.
- R9: A rising event and a software write of 0 to the same flag in one cycle leave the flag set.
- R10: While `stack_full` is 1, no request is serviced. Pending flags stay set and are serviced on the first slot after `stack_full` returns to 0.
- R11: Inside a handler, software can set the master enable and a source enable again. A pending request from that source is then serviced on the next slot.
- R12: After reset both registers read 0, `int_take` is 0 and `vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 5 | Event inputs: bit0 external 0, bit1 external 1, bit2 timer, bit3 time base, bit4 RTC |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| t2_edge | input | 1 | Service-slot qualifier from the core |
| stack_full | input | 1 | Core stack full; blocks service |
| ret_reti | input | 1 | Interrupt-return executed |
| ret_plain | input | 1 | Plain return executed |
| int_take | output | 1 | One-cycle interrupt acceptance pulse |
| vector | output | 8 | Handler address during `int_take`, else 0 |

## Verification
A write, an event edge or a return pulse driven in one cycle changes the register read-back just after the next rising edge. `int_take` and `vector` answer the `t2_edge` cycle exactly one edge later.

A behavioural model in the bench follows the same one-edge timing. It is compared with the outputs 2 ns after every rising edge, once the registers have settled. The directed checks drive inputs on the falling edge and sample after the following falling edge, so each result is read one edge after its stimulus. Events that must wait for a later service slot, such as under stack-full, are checked on that later slot explicitly.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
    localparam int NSRC = 5;
    localparam int DW   = 8;
    localparam int AW   = 8;

    // Register index (0 or 1), enable bit and flag bit per source, priority order
    localparam int SRC_REG  [NSRC] = '{0, 0, 0, 1, 1};
    localparam int SRC_ENB  [NSRC] = '{1, 2, 3, 0, 1};
    localparam int SRC_FLB  [NSRC] = '{4, 5, 6, 4, 5};
    localparam int MASTER_B = 0;

    typedef struct packed {
        logic            master;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
        logic            take;
        logic [DW-1:0]   vec;
    } ctl_state_t;
endpackage

// File: rtl/vintc_edge.sv
module vintc_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_d, prev_q;

        always_comb begin
            prev_d  = ev[i];
            rise[i] = ev[i] & ~prev_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        // R3: a held level yields only one rise
        assert_rise_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/vintc_arbiter.sv
module vintc_arbiter #(
    parameter int N        = 5,
    parameter int DW       = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [DW-1:0] vec
);
    always_comb begin
        grant = '0;
        vec   = '0;
        any   = |req;
        // scan from lowest priority up so index 0 overrides
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = DW'(VEC_BASE + VEC_STEP * i);
            end
        end
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vintc_pkg::*;
#(
    parameter logic [AW-1:0] ADDR_R0  = 8'h0B,
    parameter logic [AW-1:0] ADDR_R1  = 8'h1E,
    parameter int            VEC_BASE = 4,
    parameter int            VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_in,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            t2_edge,
    input  logic            stack_full,
    input  logic            ret_reti,
    input  logic            ret_plain,
    output logic            int_take,
    output logic [DW-1:0]   vector
);
    localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NSRC - 1);

    ctl_state_t      st_d, st_q;
    logic [NSRC-1:0] rise, req, grant;
    logic            any_req, accept, wr_r0, wr_r1;
    logic [DW-1:0]   arb_vec;

    vintc_edge #(.N(NSRC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev_in),
        .rise (rise)
    );

    assign req = st_q.flag & st_q.en;

    vintc_arbiter #(.N(NSRC), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .req  (req),
        .grant(grant),
        .any  (any_req),
        .vec  (arb_vec)
    );

    always_comb begin
        wr_r0  = reg_wr && (reg_addr == ADDR_R0);
        wr_r1  = reg_wr && (reg_addr == ADDR_R1);
        accept = t2_edge && st_q.master && !stack_full && any_req;

        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.vec  = '0;

        if (wr_r0) st_d.master = reg_wdata[MASTER_B];
        for (int i = 0; i < NSRC; i++) begin
            if ((SRC_REG[i] == 0) ? wr_r0 : wr_r1) begin
                st_d.en[i]   = reg_wdata[SRC_ENB[i]];
                st_d.flag[i] = reg_wdata[SRC_FLB[i]];
            end
        end
        if (ret_reti) st_d.master = 1'b1;
        if (accept) begin
            st_d.master = 1'b0;
            st_d.flag   = st_d.flag & ~grant;
            st_d.take   = 1'b1;
            st_d.vec    = arb_vec;
        end
        st_d.flag = st_d.flag | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_R0) begin
            reg_rdata[MASTER_B] = st_q.master;
            for (int i = 0; i < NSRC; i++) begin
                if (SRC_REG[i] == 0) begin
                    reg_rdata[SRC_ENB[i]] = st_q.en[i];
                    reg_rdata[SRC_FLB[i]] = st_q.flag[i];
                end
            end
        end else if (reg_addr == ADDR_R1) begin
            for (int i = 0; i < NSRC; i++) begin
                if (SRC_REG[i] == 1) begin
                    reg_rdata[SRC_ENB[i]] = st_q.en[i];
                    reg_rdata[SRC_FLB[i]] = st_q.flag[i];
                end
            end
        end
    end

    assign int_take = st_q.take;
    assign vector   = st_q.vec;

    // R5 and R10: acceptance only follows a slot without stack-full
    assert_take_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> ($past(t2_edge) && !$past(stack_full)));
    // R6: vector within the legal set
    assert_vec_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (vector >= DW'(VEC_BASE) && vector <= DW'(VEC_TOP)
                      && ((vector - DW'(VEC_BASE)) % DW'(VEC_STEP)) == 0));
    // R6: vector idle at zero
    assert_vec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_take |-> vector == '0);
    // R7: acceptance leaves master off and cannot repeat next cycle
    assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> !st_q.master);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> !int_take);
    // R8: interrupt-return arms master unless an acceptance overrides
    assert_reti_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_reti |=> (st_q.master || int_take));
    // R8: plain return alone keeps master
    assert_ret_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain && !ret_reti && !t2_edge && !reg_wr) |=> st_q.master == $past(st_q.master));
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev_in = '0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       t2_edge = 1'b0, stack_full = 1'b0, ret_reti = 1'b0, ret_plain = 1'b0;
    logic       int_take;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    vec_intc u_vec_intc (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t2_edge(t2_edge),
        .stack_full(stack_full), .ret_reti(ret_reti), .ret_plain(ret_plain),
        .int_take(int_take), .vector(vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_master;
    bit       m_en[5];
    bit       m_flag[5];
    bit       m_prev[5];
    bit       m_take;
    int       m_vec;
    const int vec_of[5] = '{4, 8, 12, 16, 20};

    function automatic int m_read(input logic [7:0] a);
        int r = 0;
        if (a == 8'h0B) r = m_master | (m_en[0] << 1) | (m_en[1] << 2) | (m_en[2] << 3)
                          | (m_flag[0] << 4) | (m_flag[1] << 5) | (m_flag[2] << 6);
        else if (a == 8'h1E) r = m_en[3] | (m_en[4] << 1) | (m_flag[3] << 4) | (m_flag[4] << 5);
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int win;
        bit nm;
        if (!rst_n) begin
            m_master = 0; m_take = 0; m_vec = 0;
            for (int i = 0; i < 5; i++) begin m_en[i] = 0; m_flag[i] = 0; m_prev[i] = 0; end
        end else begin
            win = -1;
            if (t2_edge && m_master && !stack_full)
                for (int i = 4; i >= 0; i--) if (m_flag[i] && m_en[i]) win = i;
            nm = m_master;
            if (reg_wr && reg_addr == 8'h0B) begin
                nm = reg_wdata[0];
                m_en[0] = reg_wdata[1]; m_en[1] = reg_wdata[2]; m_en[2] = reg_wdata[3];
                m_flag[0] = reg_wdata[4]; m_flag[1] = reg_wdata[5]; m_flag[2] = reg_wdata[6];
            end
            if (reg_wr && reg_addr == 8'h1E) begin
                m_en[3] = reg_wdata[0]; m_en[4] = reg_wdata[1];
                m_flag[3] = reg_wdata[4]; m_flag[4] = reg_wdata[5];
            end
            if (ret_reti) nm = 1;
            m_take = (win >= 0);
            m_vec  = (win >= 0) ? vec_of[win] : 0;
            if (win >= 0) begin nm = 0; m_flag[win] = 0; end
            for (int i = 0; i < 5; i++) begin
                if (ev_in[i] && !m_prev[i]) m_flag[i] = 1;
                m_prev[i] = ev_in[i];
            end
            m_master = nm;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R5 model int_take", {31'd0, int_take}, {31'd0, m_take});
            chk("R6 model vector", {24'd0, vector}, m_vec);
            chk("R1 model reg_rdata", {24'd0, reg_rdata}, m_read(reg_addr));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic slot(input bit exp_take, input logic [7:0] exp_vec, input string tag);
        @(negedge clk); t2_edge = 1;
        @(negedge clk); t2_edge = 0;
        chk(tag, {31'd0, int_take}, {31'd0, exp_take});
        chk(tag, {24'd0, vector}, {24'd0, exp_vec});
    endtask

    task automatic pulse_ret(input bit reti);
        @(negedge clk); if (reti) ret_reti = 1; else ret_plain = 1;
        @(negedge clk); ret_reti = 0; ret_plain = 0;
    endtask

    task automatic set_ev(input int i, input bit v);
        @(negedge clk); ev_in[i] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        rd(8'h0B, 8'h00, "R12 reg0 after reset");
        rd(8'h1E, 8'h00, "R12 reg1 after reset");
        chk("R12 int_take after reset", {31'd0, int_take}, 0);
        chk("R12 vector after reset", {24'd0, vector}, 0);

        // R1/R2 layout
        wr(8'h0B, 8'hFF); rd(8'h0B, 8'h7F, "R1 reg0 readback, bit7 zero");
        wr(8'h1E, 8'hFF); rd(8'h1E, 8'h33, "R2 reg1 readback, unused zero");
        rd(8'h05, 8'h00, "R2 other address reads zero");
        wr(8'h0B, 8'h00); wr(8'h1E, 8'h00);

        // R3/R4/R5: flag latched while own enable is off
        wr(8'h0B, 8'h01);
        set_ev(2, 1);
        rd(8'h0B, 8'h41, "R3 timer rise sets flag");
        slot(0, 8'h00, "R5 no take without own enable");
        rd(8'h0B, 8'h41, "R4 flag held while disabled");
        wr(8'h0B, 8'h01);
        rd(8'h0B, 8'h01, "R4 software clear");
        repeat (2) @(negedge clk);
        rd(8'h0B, 8'h01, "R3 held level does not re-set");
        set_ev(2, 0);

        // R6/R7/R8 priority walk
        wr(8'h0B, 8'h0F); wr(8'h1E, 8'h03);
        @(negedge clk); ev_in = 5'h1F;
        rd(8'h0B, 8'h7F, "R3 all reg0 flags set");
        rd(8'h1E, 8'h33, "R3 all reg1 flags set");
        slot(1, 8'h04, "R6 external 0 first");
        rd(8'h0B, 8'h6E, "R7 flag0 and master cleared");
        slot(0, 8'h00, "R7 master off blocks service");
        pulse_ret(0);
        rd(8'h0B, 8'h6E, "R8 plain return keeps master off");
        pulse_ret(1);
        rd(8'h0B, 8'h6F, "R8 interrupt-return sets master");
        slot(1, 8'h08, "R6 external 1 second");
        pulse_ret(1); slot(1, 8'h0C, "R6 timer third");
        pulse_ret(1); slot(1, 8'h10, "R6 time base fourth");
        rd(8'h1E, 8'h23, "R7 other flag stays");
        pulse_ret(1); slot(1, 8'h14, "R6 RTC last");
        rd(8'h1E, 8'h03, "R7 reg1 flags cleared");
        @(negedge clk); ev_in = 5'h00;

        // R10 stack full veto
        set_ev(0, 1);
        pulse_ret(1);
        @(negedge clk); stack_full = 1;
        slot(0, 8'h00, "R10 no take while stack full");
        rd(8'h0B, 8'h1F, "R10 flag pending under stack full");
        @(negedge clk); stack_full = 0;
        slot(1, 8'h04, "R10 serviced after stack frees");

        // R11 nested enable inside handler
        wr(8'h0B, 8'h07);
        set_ev(1, 1);
        @(negedge clk);
        slot(1, 8'h08, "R11 nested service");

        // R9 event beats software clear
        @(negedge clk); reg_wr = 1; reg_addr = 8'h1E; reg_wdata = 8'h03; ev_in[3] = 1;
        @(negedge clk); reg_wr = 0;
        rd(8'h1E, 8'h13, "R9 event wins over write");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog R5: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule